// File: doc/BRIEF.md
# Operand Effective Address Unit

This block turns the operand field of an instruction into the value that an accumulator loads. A mode code picks how the field is read. The field may be the value itself, a memory address, a register number, or a pointer to a pointer. It may also be a base or displacement that is added to a register. The unit runs as a small sequencer. It uses a register-file read port and a synchronous memory read port with one cycle of read latency, and it issues only as many memory reads as the chosen mode needs.

A caller pulses `start_i` with a mode and a field while `busy_o` is low. The unit raises `done_o` for a single cycle with the resolved value on `result_o`. Mode code 7 is not a valid mode and returns an error flag instead of a value. The register-file port is combinational. While the unit reads a register it drives `rf_sel_o`, and `rf_data_i` must carry that register in the same cycle. A memory read issued in one cycle (`mem_req_o` with `mem_addr_o`) returns its word on `mem_rdata_i` in the following cycle.

Top module: `opnd_ea_unit`

## Requirements
- R1: Mode 0 (immediate) returns the 12-bit field sign-extended to 16 bits. It issues no memory read, and done comes 1 cycle after the start edge.
- R2: Mode 1 (direct) returns the memory word at the field's address. It issues exactly one read, and done comes 3 cycles after the start edge.
- R3: Mode 2 (register) returns the register picked by field bits [2:0]. It issues no memory read, and done comes 2 cycles after the start edge.
- R4: Mode 3 (indirect) reads the word at the field's address and uses its low 12 bits as a second address. It returns the word at that second address, with exactly two reads, and done comes 5 cycles after the start edge.
- R5: Mode 4 (register-indirect) returns the memory word at the address held in the low 12 bits of the register picked by field bits [2:0]. It issues one read, and done comes 4 cycles after the start edge.
- R6: Mode 5 (indexed) returns the memory word at (field + low 12 bits of register 1) modulo 4096. It issues one read, and done comes 4 cycles after the start edge.
- R7: Mode 6 (based) returns the memory word at (low 12 bits of register 2 + field) modulo 4096. The field acts as the displacement. It issues one read, and done comes 4 cycles after the start edge.
- R8: Mode 7 is reserved. It raises `err_o` together with `done_o`, with result 0 and no memory read, 1 cycle after the start edge. `err_o` is never high without `done_o`.
- R9: `done_o` is high for exactly one cycle per accepted start.
- R10: A start pulse that arrives while `busy_o` is high, including the done cycle, is ignored. It produces no extra done and does not change the result of the operation in flight.
- R11: During reset, `done_o`, `err_o`, `busy_o` and `mem_req_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Start pulse, taken only when idle |
| mode_i | input | 3 | Addressing mode code (0..6, 7 reserved) |
| field_i | input | 12 | Operand field: constant, address, register number or displacement |
| busy_o | output | 1 | High from the start edge until the unit returns to idle |
| done_o | output | 1 | One-cycle strobe: result valid |
| err_o | output | 1 | Reserved mode code was given (only with done) |
| result_o | output | 16 | Resolved operand |
| rf_sel_o | output | 3 | Register-file read select |
| rf_data_i | input | 16 | Register-file read data for `rf_sel_o`, same cycle |
| mem_req_o | output | 1 | Memory read request |
| mem_addr_o | output | 12 | Memory read address |
| mem_rdata_i | input | 16 | Memory read data, valid the cycle after the request |

## Verification
Each mode has a fixed latency, counted from the clock edge that accepts the start to the edge after which `done_o` is high. Immediate and reserved take 1 cycle, register takes 2, direct takes 3, register-indirect, indexed and based take 4, and indirect takes 5. The driver records the bench cycle count in the half-cycle before the start edge. The monitor samples on falling edges, so it sees done at exactly that count plus the latency, and it compares the latency along with the value, the error flag and the number of memory requests seen since the previous done. A done that arrives with no operation pending counts as a failure. This is how start pulses given while busy are shown to be ignored.

// File: rtl/opnd_ea_pkg.sv
package opnd_ea_pkg;

   typedef enum logic [2:0] {
      MD_IMM  = 3'd0,
      MD_DIR  = 3'd1,
      MD_REG  = 3'd2,
      MD_IND  = 3'd3,
      MD_RIND = 3'd4,
      MD_IDX  = 3'd5,
      MD_BAS  = 3'd6,
      MD_RSV  = 3'd7
   } mode_e;

   typedef enum logic [2:0] {
      ST_IDLE = 3'd0,
      ST_REG  = 3'd1,
      ST_RD1  = 3'd2,
      ST_WT1  = 3'd3,
      ST_RD2  = 3'd4,
      ST_WT2  = 3'd5,
      ST_DONE = 3'd6
   } seq_st_e;

   function automatic logic needs_reg(mode_e m);
      return (m == MD_REG) || (m == MD_RIND) || (m == MD_IDX) || (m == MD_BAS);
   endfunction

   function automatic logic needs_mem_first(mode_e m);
      return (m == MD_DIR) || (m == MD_IND);
   endfunction

endpackage

// File: rtl/opnd_ea_addgen.sv
module opnd_ea_addgen #(
   parameter int AW = 12
) (
   input  logic [AW-1:0] base_i,
   input  logic [AW-1:0] ofs_i,
   output logic [AW-1:0] ea_o
);
   if (AW < 2) begin : g_bad_aw
      $error("opnd_ea_addgen: AW must be at least 2");
   end

   // Sum truncated to AW bits: wraps modulo 2**AW
   assign ea_o = AW'(base_i + ofs_i);

endmodule

// File: rtl/opnd_ea_immext.sv
module opnd_ea_immext #(
   parameter int AW       = 12,
   parameter int DW       = 16,
   parameter bit SIGN_EXT = 1'b1
) (
   input  logic [AW-1:0] fld_i,
   output logic [DW-1:0] val_o
);
   if (DW < AW) begin : g_bad_dw
      $error("opnd_ea_immext: DW must not be below AW");
   end else if (DW == AW) begin : g_same
      assign val_o = fld_i;
   end else if (SIGN_EXT) begin : g_sext
      assign val_o = {{(DW-AW){fld_i[AW-1]}}, fld_i};
   end else begin : g_zext
      assign val_o = {{(DW-AW){1'b0}}, fld_i};
   end

endmodule

// File: rtl/opnd_ea_seq.sv
module opnd_ea_seq
   import opnd_ea_pkg::*;
(
   input  logic    clk,
   input  logic    rst_n,
   input  logic    start_i,
   input  mode_e   mode_i,
   input  mode_e   mode_q,
   output seq_st_e state_o
);
   seq_st_e st_q, st_d;

   always_comb begin
      st_d = st_q;
      unique case (st_q)
         ST_IDLE: begin
            if (start_i) begin
               if (needs_reg(mode_i))            st_d = ST_REG;
               else if (needs_mem_first(mode_i)) st_d = ST_RD1;
               else                              st_d = ST_DONE;
            end
         end
         ST_REG:  st_d = (mode_q == MD_REG) ? ST_DONE : ST_RD1;
         ST_RD1:  st_d = ST_WT1;
         ST_WT1:  st_d = (mode_q == MD_IND) ? ST_RD2 : ST_DONE;
         ST_RD2:  st_d = ST_WT2;
         ST_WT2:  st_d = ST_DONE;
         ST_DONE: st_d = ST_IDLE;
         default: st_d = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) st_q <= ST_IDLE;
      else        st_q <= st_d;
   end

   assign state_o = st_q;

   AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_DONE) |=> (st_q == ST_IDLE)); // R9

   AST_SECOND_READ_ONLY_IND: assert property (@(posedge clk) disable iff (!rst_n)
      (st_q == ST_RD2) |-> (mode_q == MD_IND)); // R4

endmodule

// File: rtl/opnd_ea_unit.sv
module opnd_ea_unit
   import opnd_ea_pkg::*;
#(
   parameter int AW        = 12,
   parameter int DW        = 16,
   parameter int RSW       = 3,
   parameter int INDEX_REG = 1,
   parameter int BASE_REG  = 2,
   parameter bit IMM_SIGN  = 1'b1
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           start_i,
   input  logic [2:0]     mode_i,
   input  logic [AW-1:0]  field_i,
   output logic           busy_o,
   output logic           done_o,
   output logic           err_o,
   output logic [DW-1:0]  result_o,
   output logic [RSW-1:0] rf_sel_o,
   input  logic [DW-1:0]  rf_data_i,
   output logic           mem_req_o,
   output logic [AW-1:0]  mem_addr_o,
   input  logic [DW-1:0]  mem_rdata_i
);
   localparam int NREG = 1 << RSW;

   if (DW < AW) begin : g_bad_width
      $error("opnd_ea_unit: data width must cover the address width");
   end
   if (RSW > AW) begin : g_bad_rsw
      $error("opnd_ea_unit: register select wider than the field");
   end
   if (INDEX_REG >= NREG || BASE_REG >= NREG) begin : g_bad_reg
      $error("opnd_ea_unit: index or base register out of range");
   end

   mode_e            mode_in, mode_q;
   seq_st_e          st;
   logic [AW-1:0]    field_q;
   logic [AW-1:0]    ea_q;
   logic [DW-1:0]    res_q;
   logic             rsv_q;
   logic             accept;
   logic [DW-1:0]    imm_val;
   logic [AW-1:0]    ea_sum;

   assign mode_in = mode_e'(mode_i);
   assign accept  = (st == ST_IDLE) && start_i;

   opnd_ea_seq u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start_i (start_i),
      .mode_i  (mode_in),
      .mode_q  (mode_q),
      .state_o (st)
   );

   opnd_ea_immext #(.AW(AW), .DW(DW), .SIGN_EXT(IMM_SIGN)) u_imm (
      .fld_i (field_i),
      .val_o (imm_val)
   );

   opnd_ea_addgen #(.AW(AW)) u_add (
      .base_i (rf_data_i[AW-1:0]),
      .ofs_i  (field_q),
      .ea_o   (ea_sum)
   );

   // Register select: fixed index/base registers, else field low bits
   always_comb begin
      unique case (mode_q)
         MD_IDX:  rf_sel_o = RSW'(INDEX_REG);
         MD_BAS:  rf_sel_o = RSW'(BASE_REG);
         default: rf_sel_o = field_q[RSW-1:0];
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q  <= MD_IMM;
         field_q <= '0;
         ea_q    <= '0;
         res_q   <= '0;
         rsv_q   <= 1'b0;
      end else begin
         unique case (st)
            ST_IDLE: begin
               if (accept) begin
                  mode_q  <= mode_in;
                  field_q <= field_i;
                  ea_q    <= field_i;
                  rsv_q   <= (mode_in == MD_RSV);
                  res_q   <= (mode_in == MD_IMM) ? imm_val : '0;
               end
            end
            ST_REG: begin
               if (mode_q == MD_REG)       res_q <= rf_data_i;
               else if (mode_q == MD_RIND) ea_q  <= rf_data_i[AW-1:0];
               else                        ea_q  <= ea_sum;
            end
            ST_WT1: begin
               if (mode_q == MD_IND) ea_q  <= mem_rdata_i[AW-1:0];
               else                  res_q <= mem_rdata_i;
            end
            ST_WT2:  res_q <= mem_rdata_i;
            default: ;
         endcase
      end
   end

   assign busy_o     = (st != ST_IDLE);
   assign done_o     = (st == ST_DONE);
   assign err_o      = done_o && rsv_q;
   assign result_o   = res_q;
   assign mem_req_o  = (st == ST_RD1) || (st == ST_RD2);
   assign mem_addr_o = ea_q;

   AST_NO_MEM_SHORT_MODES: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> !(mode_q inside {MD_IMM, MD_REG, MD_RSV})); // R1

   AST_REQ_THEN_WAIT: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |=> !mem_req_o); // R2

   AST_IND_CHAIN: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RD2) |-> (mem_addr_o == $past(mem_rdata_i[AW-1:0]))); // R4

   AST_ERR_ONLY_RSV: assert property (@(posedge clk) disable iff (!rst_n)
      err_o |-> (done_o && mode_q == MD_RSV)); // R8

   AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
      (busy_o && start_i) |=> ($stable(mode_q) && $stable(field_q))); // R10

   AST_RESET_QUIET: assert property (@(posedge clk)
      !rst_n |=> (!done_o && !mem_req_o && !busy_o)); // R11

endmodule

// File: tb/tb_opnd_ea_unit.sv
`timescale 1ns/1ps
module tb_opnd_ea_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start_i = 1'b0;
   logic [2:0]  mode_i = '0;
   logic [11:0] field_i = '0;
   logic        busy_o, done_o, err_o, mem_req_o;
   logic [15:0] result_o, rf_data_i;
   logic [2:0]  rf_sel_o;
   logic [11:0] mem_addr_o;
   logic [15:0] mem_rdata_i = '0;

   always #2.5 clk = ~clk;

   opnd_ea_unit dut (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .mode_i(mode_i), .field_i(field_i),
      .busy_o(busy_o), .done_o(done_o), .err_o(err_o), .result_o(result_o),
      .rf_sel_o(rf_sel_o), .rf_data_i(rf_data_i),
      .mem_req_o(mem_req_o), .mem_addr_o(mem_addr_o), .mem_rdata_i(mem_rdata_i)
   );

   // Register file and memory models
   logic [15:0] rf [8];
   assign rf_data_i = rf[rf_sel_o];

   function automatic logic [15:0] mv(logic [11:0] a);
      return {a[7:0], a[11:4]} ^ 16'h3C5A;
   endfunction

   always_ff @(posedge clk) if (mem_req_o) mem_rdata_i <= mv(mem_addr_o);

   int cyc = 0;
   always @(posedge clk) cyc <= cyc + 1;

   int checks = 0;
   int failures = 0;
   int dones = 0;
   int nreq = 0;
   bit finished = 1'b0;

   typedef struct {
      logic [15:0] val;
      logic        err;
      int          lat;
      int          req;
      int          t0;
      string       tag;
   } exp_t;
   exp_t q[$];

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s %s actual=0x%0h expected=0x%0h", tag, what, act, exp);
      end
   endtask

   // Monitor: compares each done against the head of the scoreboard
   always @(negedge clk) begin
      if (rst_n) begin
         if (mem_req_o) nreq++;
         if (done_o) begin
            dones++;
            if (q.size() == 0) begin
               chk(1'b0, "R10", "done with nothing pending", 1, 0);
            end else begin
               exp_t e;
               e = q.pop_front();
               chk(result_o == e.val, e.tag, "result", int'(result_o), int'(e.val));
               chk(err_o == e.err, e.tag, "err", int'(err_o), int'(e.err));
               chk(cyc - e.t0 == e.lat, e.tag, "latency", cyc - e.t0, e.lat);
               chk(nreq == e.req, e.tag, "mem reads", nreq, e.req);
            end
            nreq = 0;
         end else if (err_o) begin
            chk(1'b0, "R8", "err without done", 1, 0);
         end
      end
   end

   function automatic exp_t model(logic [2:0] m, logic [11:0] f, string tag);
      exp_t e;
      e.err = 1'b0; e.tag = tag; e.t0 = 0;
      case (m)
         3'd0: begin e.val = {{4{f[11]}}, f};                  e.lat = 1; e.req = 0; end
         3'd1: begin e.val = mv(f);                            e.lat = 3; e.req = 1; end
         3'd2: begin e.val = rf[f[2:0]];                       e.lat = 2; e.req = 0; end
         3'd3: begin e.val = mv(mv(f)[11:0]);                  e.lat = 5; e.req = 2; end
         3'd4: begin e.val = mv(rf[f[2:0]][11:0]);             e.lat = 4; e.req = 1; end
         3'd5: begin e.val = mv(12'(f + rf[1][11:0]));         e.lat = 4; e.req = 1; end
         3'd6: begin e.val = mv(12'(rf[2][11:0] + f));         e.lat = 4; e.req = 1; end
         default: begin e.val = '0; e.err = 1'b1;              e.lat = 1; e.req = 0; end
      endcase
      return e;
   endfunction

   task automatic wait_drain();
      for (int i = 0; i < 50 && q.size() != 0; i++) @(negedge clk);
      @(negedge clk);
   endtask

   // Driver: optionally pokes a second start while busy
   task automatic run_op(logic [2:0] m, logic [11:0] f, string tag, bit poke);
      exp_t e;
      @(negedge clk);
      while (busy_o) @(negedge clk);
      e = model(m, f, tag);
      e.t0 = cyc;
      q.push_back(e);
      mode_i = m; field_i = f; start_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      if (poke) begin
         mode_i = 3'd0; field_i = 12'h123; start_i = 1'b1;
         @(negedge clk);
         start_i = 1'b0;
         while (!done_o) @(negedge clk);
         mode_i = 3'd2; field_i = 12'h005; start_i = 1'b1; // during done cycle
         @(negedge clk);
         start_i = 1'b0;
      end
      wait_drain();
   endtask

   initial begin
      for (int i = 0; i < 8; i++) rf[i] = 16'h0A00 + 16'(i * 16'h0135);
      rf[1] = 16'h7FF0;   // index register, low 12 bits near top of range
      rf[2] = 16'h0200;   // base register
      rf[5] = 16'h8ABC;

      repeat (3) @(negedge clk);
      chk(!done_o && !err_o && !busy_o && !mem_req_o, "R11", "reset outputs",
          {done_o, err_o, busy_o, mem_req_o}, 0);
      rst_n = 1'b1;

      run_op(3'd0, 12'h800, "R1", 1'b0);
      run_op(3'd0, 12'h7FF, "R1", 1'b0);
      run_op(3'd1, 12'h0C4, "R2", 1'b0);
      run_op(3'd1, 12'hFFF, "R2", 1'b0);
      run_op(3'd2, 12'h005, "R3", 1'b0);
      run_op(3'd2, 12'hF83, "R3", 1'b0);
      run_op(3'd3, 12'h321, "R4", 1'b0);
      run_op(3'd3, 12'h000, "R4", 1'b0);
      run_op(3'd4, 12'h005, "R5", 1'b0);
      run_op(3'd4, 12'h003, "R5", 1'b0);
      run_op(3'd5, 12'h020, "R6", 1'b0);   // wraps past 4095
      run_op(3'd5, 12'h004, "R6", 1'b0);
      run_op(3'd6, 12'h010, "R7", 1'b0);
      run_op(3'd6, 12'hE80, "R7", 1'b0);   // wraps past 4095
      run_op(3'd7, 12'h555, "R8", 1'b0);
      run_op(3'd3, 12'h456, "R10", 1'b1);
      run_op(3'd1, 12'h0AA, "R10", 1'b1);

      repeat (4) @(negedge clk);
      chk(dones == 17, "R9", "done count", dones, 17);
      chk(!busy_o && !done_o, "R10", "idle after ignored starts", {busy_o, done_o}, 0);

      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!finished) begin
         checks++;
         failures++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

endmodule